// File: doc/BRIEF.md
# Two-Bank Name-Prefix Lookup Sequencer

This block steps a single forwarding lookup, or a single table update, through two filter banks that summarise the name prefixes a router knows about. A request carries the number of components in the name, two sets of precomputed hash positions (one per bank), a lookup/update selector and, for updates, a payload. The sequencer picks one bank from the component count and sends that bank's hash positions to it as a one-cycle query. It then waits for the bank's hit flag and mapping value.

The mapping value is used directly as the address into a record store. If a lookup hits in the filter, the record at that address is read. A record with its valid bit set gives a hit response carrying the payload. A record with the valid bit clear means the entry has expired. In that case a delete request goes to the counting filter of the same bank, and the response reports a miss. A filter miss is answered at once, with no access to the record store.

An update runs in a fixed order: query the bank, write the record at the mapping address, then send an insert to the counting filter. Only one request is in flight at a time. The request side stays not-ready until the response has been taken.

Top module: `pfx_lookup_ctrl`

## Requirements
- R1: A request whose component count equals MAIN_NCOMP (default 4) queries bank 0 with the first hash set. Any other count queries bank 1 with the second hash set. The bank number is the bit index in `flt_q_valid`, and at most one bit is set.
- R2: Each accepted request raises `flt_q_valid` for exactly one cycle, in the cycle after acceptance.
- R3: A lookup that gets a filter miss produces a response with `rsp_hit`=0 and `rsp_data`=0. No record read, record write or counting-filter request takes place.
- R4: A lookup that gets a filter hit reads the record store once, at the address given by the selected bank's mapping value.
- R5: When that record has its valid bit set, the response has `rsp_hit`=1, the bank number, the mapping value as offset, and the record payload as data. The valid bit is the top bit of `rec_rd_data` (bit DW); the payload is bits DW-1:0.
- R6: When that record's valid bit is clear, a counting-filter request with `cnt_del`=1 goes out, carrying the selected bank and its hash positions. It is held until `cnt_ready`, and then the response has `rsp_hit`=0 and `rsp_data`=0.
- R7: An update queries the bank, then writes `{1'b1, payload}` at the mapping value, then sends a counting-filter request with `cnt_del`=0. Its response carries the filter hit flag, the offset and the written payload, and no record read takes place.
- R8: `req_ready` is low from acceptance until the response is accepted. The response fields hold steady while `rsp_valid` is high and `rsp_ready` is low.
- R9: Filter responses from the bank that was not queried, and any filter, record or counting-filter responses that arrive while idle, have no effect.
- R10: Reset, applied at any point, returns the block to idle: `req_ready`=1, and no query, record access, counting-filter request or response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_update | input | 1 | 1 = update, 0 = lookup |
| req_ncomp | input | CW | Name component count |
| req_pos0 | input | PW | K hash positions for bank 0 |
| req_pos1 | input | PW | K hash positions for bank 1 |
| req_wdata | input | DW | Payload written by an update |
| flt_q_valid | output | 2 | One-cycle query strobe, one bit per bank |
| flt_q_pos | output | PW | Hash positions of the queried bank |
| flt_r_valid | input | 2 | Filter response strobe per bank |
| flt_r_hit | input | 2 | Filter hit flag per bank |
| flt_r_map | input | 2*MW | Mapping value per bank |
| rec_rd_en | output | 1 | Record read strobe |
| rec_rd_addr | output | MW | Record read address |
| rec_rd_valid | input | 1 | Record read data present |
| rec_rd_data | input | DW+1 | Record: valid bit on top, payload below |
| rec_wr_en | output | 1 | Record write strobe |
| rec_wr_addr | output | MW | Record write address |
| rec_wr_data | output | DW+1 | Record written: valid bit on top, payload below |
| cnt_valid | output | 1 | Counting-filter request present |
| cnt_ready | input | 1 | Counting filter takes the request |
| cnt_del | output | 1 | 1 = delete, 0 = insert |
| cnt_bank | output | 1 | Bank the request is for |
| cnt_pos | output | PW | Hash positions for the counting filter |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Hit flag |
| rsp_bank | output | 1 | Bank used |
| rsp_offset | output | MW | Mapping value / record address |
| rsp_data | output | DW | Record payload, or zero on a miss |

## Verification
The assertions assume that a filter bank answers only after it has seen its one-cycle query strobe. They also assume that the record store answers only after the read strobe, and that `cnt_ready` is sampled only while a counting-filter request is pending. Any stray responses outside those windows are assumed to be ignored, not forbidden. The stimulus keeps to these rules for the selected bank. It deliberately breaks them for the other bank and while idle, so that R9 is exercised at the ports. Hit flags and mapping values come from a vector table, so every combination of bank, filter hit and record validity is covered.

// File: rtl/pfx_lookup_pkg.sv
package pfx_lookup_pkg;
  localparam int NBANK = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUERY,
    ST_QWAIT,
    ST_READ,
    ST_RWAIT,
    ST_WRITE,
    ST_CNT,
    ST_RESP
  } seq_state_t;
endpackage

// File: rtl/pfx_bank_sel.sv
module pfx_bank_sel #(
  parameter int CW         = 4,
  parameter int PW         = 32,
  parameter int MAIN_NCOMP = 4
) (
  input  logic [CW-1:0] ncomp,
  input  logic [PW-1:0] pos0,
  input  logic [PW-1:0] pos1,
  output logic          bank,
  output logic [PW-1:0] pos
);
  function automatic logic bank_for(input logic [CW-1:0] n);
    return (n == CW'(MAIN_NCOMP)) ? 1'b0 : 1'b1;
  endfunction

  assign bank = bank_for(ncomp);
  assign pos  = bank ? pos1 : pos0;
endmodule

// File: rtl/pfx_bank_port.sv
module pfx_bank_port
  import pfx_lookup_pkg::*;
#(
  parameter int MW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                q_fire,
  input  logic                cur_bank,
  input  logic [NBANK-1:0]    flt_r_valid,
  input  logic [NBANK-1:0]    flt_r_hit,
  input  logic [NBANK*MW-1:0] flt_r_map,
  output logic [NBANK-1:0]    flt_q_valid,
  output logic                sel_valid,
  output logic                sel_hit,
  output logic [MW-1:0]       sel_map
);
  logic [NBANK-1:0] own_rsp;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign flt_q_valid[b] = q_fire && (int'(cur_bank) == b);
    assign own_rsp[b]     = flt_r_valid[b] && (int'(cur_bank) == b);
  end

  always_comb begin
    sel_valid = |own_rsp;
    sel_hit   = 1'b0;
    sel_map   = '0;
    for (int i = 0; i < NBANK; i++) begin
      sel_hit = sel_hit | (own_rsp[i] & flt_r_hit[i]);
      sel_map = sel_map | ({MW{own_rsp[i]}} & flt_r_map[i*MW +: MW]);
    end
  end

  p_one_query_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flt_q_valid));
  p_query_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|flt_q_valid) |=> !(|flt_q_valid));
endmodule

// File: rtl/pfx_lookup_seq.sv
module pfx_lookup_seq
  import pfx_lookup_pkg::*;
#(
  parameter int PW = 32,
  parameter int MW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_update,
  input  logic          req_bank,
  input  logic [PW-1:0] req_pos,
  input  logic [DW-1:0] req_wdata,
  output logic          q_fire,
  output logic          cur_bank,
  output logic [PW-1:0] q_pos,
  input  logic          sel_valid,
  input  logic          sel_hit,
  input  logic [MW-1:0] sel_map,
  output logic          rec_rd_en,
  output logic [MW-1:0] rec_rd_addr,
  input  logic          rec_rd_valid,
  input  logic [DW:0]   rec_rd_data,
  output logic          rec_wr_en,
  output logic [MW-1:0] rec_wr_addr,
  output logic [DW:0]   rec_wr_data,
  output logic          cnt_valid,
  input  logic          cnt_ready,
  output logic          cnt_del,
  output logic          cnt_bank,
  output logic [PW-1:0] cnt_pos,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_hit,
  output logic          rsp_bank,
  output logic [MW-1:0] rsp_offset,
  output logic [DW-1:0] rsp_data
);
  seq_state_t    state;
  logic          upd_q, bank_q, hit_q, del_q;
  logic [PW-1:0] pos_q;
  logic [DW-1:0] wdata_q, data_q;
  logic [MW-1:0] map_q;

  // named events for assertions
  logic accept_ev, filt_done_ev, rec_done_ev, rec_live;
  assign accept_ev    = (state == ST_IDLE)  && req_valid;
  assign filt_done_ev = (state == ST_QWAIT) && sel_valid;
  assign rec_done_ev  = (state == ST_RWAIT) && rec_rd_valid;
  assign rec_live     = rec_rd_data[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      upd_q   <= 1'b0;
      bank_q  <= 1'b0;
      hit_q   <= 1'b0;
      del_q   <= 1'b0;
      pos_q   <= '0;
      wdata_q <= '0;
      data_q  <= '0;
      map_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept_ev) begin
          upd_q   <= req_update;
          bank_q  <= req_bank;
          pos_q   <= req_pos;
          wdata_q <= req_wdata;
          state   <= ST_QUERY;
        end
        ST_QUERY: state <= ST_QWAIT;
        ST_QWAIT: if (filt_done_ev) begin
          hit_q <= sel_hit;
          map_q <= sel_map;
          if (upd_q)        state <= ST_WRITE;
          else if (sel_hit) state <= ST_READ;
          else begin
            data_q <= '0;
            state  <= ST_RESP;
          end
        end
        ST_READ: state <= ST_RWAIT;
        ST_RWAIT: if (rec_done_ev) begin
          if (rec_live) begin
            data_q <= rec_rd_data[DW-1:0];
            state  <= ST_RESP;
          end else begin
            hit_q  <= 1'b0;
            data_q <= '0;
            del_q  <= 1'b1;
            state  <= ST_CNT;
          end
        end
        ST_WRITE: begin
          data_q <= wdata_q;
          del_q  <= 1'b0;
          state  <= ST_CNT;
        end
        ST_CNT:  if (cnt_ready) state <= ST_RESP;
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign q_fire      = (state == ST_QUERY);
  assign cur_bank    = bank_q;
  assign q_pos       = pos_q;
  assign rec_rd_en   = (state == ST_READ);
  assign rec_rd_addr = map_q;
  assign rec_wr_en   = (state == ST_WRITE);
  assign rec_wr_addr = map_q;
  assign rec_wr_data = {1'b1, wdata_q};
  assign cnt_valid   = (state == ST_CNT);
  assign cnt_del     = del_q;
  assign cnt_bank    = bank_q;
  assign cnt_pos     = pos_q;
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_hit     = hit_q;
  assign rsp_bank    = bank_q;
  assign rsp_offset  = map_q;
  assign rsp_data    = data_q;

  p_query_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> q_fire);
  p_miss_skips_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_done_ev && !sel_hit && !upd_q) |=> rsp_valid && !rsp_hit);
  p_hit_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_done_ev && sel_hit && !upd_q) |=> rec_rd_en && (rec_rd_addr == $past(sel_map)));
  p_dead_record_deletes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done_ev && !rec_live) |=> cnt_valid && cnt_del);
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_valid && !cnt_ready) |=> cnt_valid && $stable({cnt_del, cnt_bank, cnt_pos}));
  p_update_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_done_ev && upd_q) |=> rec_wr_en);
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !req_ready);
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable({rsp_hit, rsp_bank, rsp_offset, rsp_data}));
  p_single_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, q_fire, rec_rd_en, rec_wr_en, cnt_valid, rsp_valid}));
endmodule

// File: rtl/pfx_lookup_ctrl.sv
module pfx_lookup_ctrl
  import pfx_lookup_pkg::*;
#(
  parameter int K          = 4,
  parameter int HW         = 8,
  parameter int CW         = 4,
  parameter int MW         = 6,
  parameter int DW         = 16,
  parameter int MAIN_NCOMP = 4,
  localparam int PW        = K * HW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_update,
  input  logic [CW-1:0]       req_ncomp,
  input  logic [PW-1:0]       req_pos0,
  input  logic [PW-1:0]       req_pos1,
  input  logic [DW-1:0]       req_wdata,
  output logic [NBANK-1:0]    flt_q_valid,
  output logic [PW-1:0]       flt_q_pos,
  input  logic [NBANK-1:0]    flt_r_valid,
  input  logic [NBANK-1:0]    flt_r_hit,
  input  logic [NBANK*MW-1:0] flt_r_map,
  output logic                rec_rd_en,
  output logic [MW-1:0]       rec_rd_addr,
  input  logic                rec_rd_valid,
  input  logic [DW:0]         rec_rd_data,
  output logic                rec_wr_en,
  output logic [MW-1:0]       rec_wr_addr,
  output logic [DW:0]         rec_wr_data,
  output logic                cnt_valid,
  input  logic                cnt_ready,
  output logic                cnt_del,
  output logic                cnt_bank,
  output logic [PW-1:0]       cnt_pos,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_hit,
  output logic                rsp_bank,
  output logic [MW-1:0]       rsp_offset,
  output logic [DW-1:0]       rsp_data
);
  logic          req_bank, q_fire, cur_bank, sel_valid, sel_hit;
  logic [PW-1:0] req_pos;
  logic [MW-1:0] sel_map;

  pfx_bank_sel #(.CW(CW), .PW(PW), .MAIN_NCOMP(MAIN_NCOMP)) u_sel (
    .ncomp(req_ncomp), .pos0(req_pos0), .pos1(req_pos1),
    .bank(req_bank), .pos(req_pos)
  );

  pfx_bank_port #(.MW(MW)) u_port (
    .clk(clk), .rst_n(rst_n), .q_fire(q_fire), .cur_bank(cur_bank),
    .flt_r_valid(flt_r_valid), .flt_r_hit(flt_r_hit), .flt_r_map(flt_r_map),
    .flt_q_valid(flt_q_valid), .sel_valid(sel_valid), .sel_hit(sel_hit),
    .sel_map(sel_map)
  );

  pfx_lookup_seq #(.PW(PW), .MW(MW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_update(req_update),
    .req_bank(req_bank), .req_pos(req_pos), .req_wdata(req_wdata),
    .q_fire(q_fire), .cur_bank(cur_bank), .q_pos(flt_q_pos),
    .sel_valid(sel_valid), .sel_hit(sel_hit), .sel_map(sel_map),
    .rec_rd_en(rec_rd_en), .rec_rd_addr(rec_rd_addr),
    .rec_rd_valid(rec_rd_valid), .rec_rd_data(rec_rd_data),
    .rec_wr_en(rec_wr_en), .rec_wr_addr(rec_wr_addr), .rec_wr_data(rec_wr_data),
    .cnt_valid(cnt_valid), .cnt_ready(cnt_ready), .cnt_del(cnt_del),
    .cnt_bank(cnt_bank), .cnt_pos(cnt_pos),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_bank(rsp_bank), .rsp_offset(rsp_offset), .rsp_data(rsp_data)
  );
endmodule

// File: tb/pfx_lookup_ctrl_tb.sv
module pfx_lookup_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K = 4, HW = 8, CW = 4, MW = 6, DW = 16, PW = K * HW;
  localparam int NV = 9;
  // {update, ncomp[3:0], filter_hit, record_valid, map[5:0], data[15:0]}
  localparam logic [28:0] VECS [NV] = '{
    {1'b0, 4'd4,  1'b1, 1'b1, 6'h05, 16'hBEEF},
    {1'b0, 4'd3,  1'b1, 1'b1, 6'h2A, 16'h1234},
    {1'b0, 4'd4,  1'b0, 1'b0, 6'h11, 16'h0000},
    {1'b0, 4'd7,  1'b0, 1'b0, 6'h3F, 16'h0000},
    {1'b0, 4'd4,  1'b1, 1'b0, 6'h09, 16'hDEAD},
    {1'b0, 4'd0,  1'b1, 1'b0, 6'h00, 16'h0F0F},
    {1'b1, 4'd4,  1'b0, 1'b0, 6'h17, 16'hCAFE},
    {1'b1, 4'd15, 1'b1, 1'b0, 6'h3E, 16'hA5A5},
    {1'b0, 4'd5,  1'b1, 1'b1, 6'h3E, 16'h7777}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_update = 0;
  logic [CW-1:0] req_ncomp = '0;
  logic [PW-1:0] req_pos0 = '0, req_pos1 = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] flt_r_valid = '0, flt_r_hit = '0;
  logic [2*MW-1:0] flt_r_map = '0;
  logic rec_rd_valid = 0;
  logic [DW:0] rec_rd_data = '0;
  logic cnt_ready = 0, rsp_ready = 0;
  logic req_ready, rec_rd_en, rec_wr_en, cnt_valid, cnt_del, cnt_bank;
  logic rsp_valid, rsp_hit, rsp_bank;
  logic [1:0] flt_q_valid;
  logic [PW-1:0] flt_q_pos, cnt_pos;
  logic [MW-1:0] rec_rd_addr, rec_wr_addr, rsp_offset;
  logic [DW:0] rec_wr_data;
  logic [DW-1:0] rsp_data;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_lookup_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_update(req_update), .req_ncomp(req_ncomp), .req_pos0(req_pos0),
    .req_pos1(req_pos1), .req_wdata(req_wdata), .flt_q_valid(flt_q_valid),
    .flt_q_pos(flt_q_pos), .flt_r_valid(flt_r_valid), .flt_r_hit(flt_r_hit),
    .flt_r_map(flt_r_map), .rec_rd_en(rec_rd_en), .rec_rd_addr(rec_rd_addr),
    .rec_rd_valid(rec_rd_valid), .rec_rd_data(rec_rd_data), .rec_wr_en(rec_wr_en),
    .rec_wr_addr(rec_wr_addr), .rec_wr_data(rec_wr_data), .cnt_valid(cnt_valid),
    .cnt_ready(cnt_ready), .cnt_del(cnt_del), .cnt_bank(cnt_bank), .cnt_pos(cnt_pos),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_bank(rsp_bank), .rsp_offset(rsp_offset), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_outputs(input string tag);
    chk({tag, " ready"}, 64'(req_ready), 64'd1);
    chk({tag, " no activity"},
        64'({flt_q_valid, rec_rd_en, rec_wr_en, cnt_valid, rsp_valid}), 64'd0);
  endtask

  task automatic run_vec(input logic [28:0] v, input logic [PW-1:0] p0, input logic [PW-1:0] p1);
    logic upd, fhit, rv, bank, exp_rd, exp_wr, exp_cnt, exp_del, exp_hit;
    logic saw_rd, saw_wr, saw_cnt, rd_pend, stalled, done;
    logic [CW-1:0] nc;
    logic [MW-1:0] fmap;
    logic [DW-1:0] dat, exp_data;
    logic [PW-1:0] exp_pos;
    upd = v[28]; nc = v[27:24]; fhit = v[23]; rv = v[22]; fmap = v[21:16]; dat = v[15:0];
    bank    = (nc != 4'd4);
    exp_pos = bank ? p1 : p0;
    exp_rd  = !upd && fhit;
    exp_del = !upd && fhit && !rv;
    exp_wr  = upd;
    exp_cnt = upd || exp_del;
    exp_hit = upd ? fhit : (fhit && rv);
    exp_data = upd ? dat : (exp_hit ? dat : '0);
    saw_rd = 0; saw_wr = 0; saw_cnt = 0; rd_pend = 0; stalled = 0; done = 0;

    @(negedge clk);
    chk("R8 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1; req_update = upd; req_ncomp = nc; req_pos0 = p0; req_pos1 = p1; req_wdata = dat;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R1 query bank", 64'(flt_q_valid), bank ? 64'd2 : 64'd1);
    chk("R1 query positions", 64'(flt_q_pos), 64'(exp_pos));
    chk("R8 busy after accept", 64'(req_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R2 single query cycle", 64'(flt_q_valid), 64'd0);
    // R9: response from the other bank, opposite content
    flt_r_valid = bank ? 2'b01 : 2'b10;
    flt_r_hit   = bank ? {1'b0, ~fhit} : {~fhit, 1'b0};
    flt_r_map   = bank ? {6'h00, ~fmap} : {~fmap, 6'h00};
    @(posedge clk); @(negedge clk);
    chk("R9 other bank ignored", 64'({rec_rd_en, rec_wr_en, rsp_valid}), 64'd0);
    flt_r_valid = bank ? 2'b10 : 2'b01;
    flt_r_hit   = bank ? {fhit, 1'b0} : {1'b0, fhit};
    flt_r_map   = bank ? {fmap, 6'h00} : {6'h00, fmap};
    @(posedge clk); @(negedge clk);
    flt_r_valid = '0; flt_r_hit = '0; flt_r_map = '0;
    for (int c = 0; c < 14 && !done; c++) begin
      rec_rd_valid = 0; cnt_ready = 0;
      if (rd_pend) begin
        rec_rd_valid = 1; rec_rd_data = {rv, dat}; rd_pend = 0;
      end
      if (rec_rd_en) begin
        saw_rd = 1; rd_pend = 1;
        chk("R4 read address", 64'(rec_rd_addr), 64'(fmap));
      end
      if (rec_wr_en) begin
        saw_wr = 1;
        chk("R7 write address", 64'(rec_wr_addr), 64'(fmap));
        chk("R7 write data", 64'(rec_wr_data), 64'({1'b1, dat}));
      end
      if (cnt_valid) begin
        saw_cnt = 1;
        chk("R6 counting op", 64'(cnt_del), 64'(exp_del));
        chk("R6 counting bank", 64'(cnt_bank), 64'(bank));
        chk("R6 counting positions", 64'(cnt_pos), 64'(exp_pos));
        cnt_ready = 1;
      end
      if (rsp_valid) begin
        chk("R5 response hit", 64'(rsp_hit), 64'(exp_hit));
        chk("R5 response bank", 64'(rsp_bank), 64'(bank));
        chk("R5 response offset", 64'(rsp_offset), 64'(fmap));
        chk("R3 response data", 64'(rsp_data), 64'(exp_data));
        chk("R8 busy during response", 64'(req_ready), 64'd0);
        if (!stalled) begin
          stalled = 1; rsp_ready = 0;
        end else begin
          rsp_ready = 1; done = 1;
        end
      end
      @(posedge clk); @(negedge clk);
    end
    rec_rd_valid = 0; cnt_ready = 0; rsp_ready = 0;
    chk("R8 response completed", 64'(done), 64'd1);
    chk("R8 idle after response", 64'({req_ready, rsp_valid}), 64'b10);
    chk("R4 read seen", 64'(saw_rd), 64'(exp_rd));
    chk("R7 write seen", 64'(saw_wr), 64'(exp_wr));
    chk("R3 counting request seen", 64'(saw_cnt), 64'(exp_cnt));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_outputs("R10 in reset");
    rst_n = 1;
    @(negedge clk);
    idle_outputs("R10 after reset");

    for (int i = 0; i < NV; i++)
      run_vec(VECS[i], 32'hA000_0000 | 32'(i), 32'h5000_0000 | (32'(i) << 4));

    // R9: stray responses while idle
    @(negedge clk);
    flt_r_valid = 2'b11; flt_r_hit = 2'b11; rec_rd_valid = 1; rec_rd_data = '1; cnt_ready = 1;
    @(posedge clk); @(negedge clk);
    flt_r_valid = '0; flt_r_hit = '0; rec_rd_valid = 0; cnt_ready = 0;
    @(posedge clk); @(negedge clk);
    idle_outputs("R9 idle noise");
    run_vec(VECS[0], 32'h1111_2222, 32'h3333_4444);

    // R10: reset in the middle of a lookup
    @(negedge clk);
    req_valid = 1; req_update = 0; req_ncomp = 4'd9;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R10 query started", 64'(flt_q_valid), 64'd2);
    @(posedge clk); @(negedge clk);
    rst_n = 0;
    #1;
    idle_outputs("R10 mid-run reset");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle_outputs("R10 released");
    run_vec(VECS[4], 32'h0BAD_F00D, 32'h600D_CAFE);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule